// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

An eight-bit general-purpose I/O port. Software sets a direction byte and a port byte through a small addressed register bus, and it reads the synchronized pin levels back. Each pad is presented as four separate signals: an output value, an output enable, a pull-up enable and an input level. The output value, output enable and pull-up enable are registered.

Several pins are shared with on-chip peripherals. These are the SPI data and select lines, a timer compare-match output and the clock pin of a synchronous USART. When one of these functions is active, it can force a pin to be an input, or it can take over the value driven on the pin, or both. Where it forces a pin to input, software still controls that pin's pull-up through the port byte. The SPI core and the USART receive their input levels from the synchronized pin values.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction and port bytes are zero, and pin_oe, pin_out and pin_pue are all zero.
- R2: A write stores bus_wdata at address 1 (direction byte) or address 2 (port byte). Writes to address 0 and address 3 change nothing. bus_rdata shows, one cycle after bus_addr is presented, the pin-read byte (address 0), the direction byte (address 1), the port byte (address 2) or zero (address 3).
- R3: With no peripheral override, pin_oe[i] equals direction bit i and pin_out[i] equals port bit i. Both follow a register change by one clock.
- R4: pin_pue[i] is 1 exactly when pin i is not output-enabled, port bit i is 1 and pud is 0. This holds for pins forced to input by a peripheral as well.
- R5: A change on pin_in is absent from the pin-read byte two clocks later. It is present three clocks later at bus_rdata, which is two synchronizer stages plus the read register.
- R6: In SPI slave mode (spi_en=1, spi_master=0), the MOSI pin (bit 5) and the SS pin (bit 4) are forced to input whatever their direction bits hold. The MISO pin (bit 6) drives spi_miso_out, with its output enable taken from its direction bit.
- R7: In SPI master mode (spi_en=1, spi_master=1), the MISO pin is forced to input. The MOSI pin drives spi_mosi_out, with its output enable taken from its direction bit. The SS pin behaves as plain GPIO.
- R8: spi_ss_active is 1 only when spi_en=1, spi_master=0 and the synchronized SS pin level is 0.
- R9: spi_sdi carries the synchronized MISO level in master mode and the synchronized MOSI level in slave mode. It is 0 while the SPI is disabled.
- R10: With cmp_en=1, the compare pin (bit 3) drives cmp_out only when its direction bit is 1. Otherwise the pin stays plain GPIO.
- R11: With usart_sync=1, the clock pin (bit 0) drives usart_clk_out when its direction bit is 1. When its direction bit is 0, usart_clk_in carries its synchronized level. With usart_sync=0 the pin is plain GPIO and usart_clk_in is 0.
- R12: pud=1 forces every pin_pue bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pud | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_mosi_out | input | 1 | Master serial output from the SPI core |
| spi_miso_out | input | 1 | Slave serial output from the SPI core |
| spi_sdi | output | 1 | Serial input to the SPI core |
| spi_ss_active | output | 1 | Slave selected |
| cmp_en | input | 1 | Compare output enabled |
| cmp_out | input | 1 | Compare-match output level |
| usart_sync | input | 1 | USART in synchronous mode |
| usart_clk_out | input | 1 | USART clock to drive out |
| usart_clk_in | output | 1 | USART clock taken from the pin |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pue | output | 8 | Pad pull-up enables |

## Verification
The hardest condition to create from the ports is a pin forced to input while its direction bit is 1 and its port bit is 1. That is the only case where a wrong pull-up decision shows. To reach it, the bench writes all-ones or chosen bytes into the direction and port registers before it switches the SPI into slave or master mode, and then it compares the whole pad vector. The synchronizer depth is measured by changing pin_in while address 0 is held and sampling bus_rdata after exactly two and after three edges.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  port_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      port_q <= '0;
    end else if (bus_we) begin
      if (sel == SEL_DIR)  dir_q  <= bus_wdata;
      if (sel == SEL_PORT) port_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (sel)
        SEL_PIN:  bus_rdata <= pin_sync;
        SEL_DIR:  bus_rdata <= dir_q;
        SEL_PORT: bus_rdata <= port_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_override.sv
module gpio_override #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned P_XCK  = 0,
  parameter int unsigned P_CMP  = 3,
  parameter int unsigned P_SS   = 4,
  parameter int unsigned P_MOSI = 5,
  parameter int unsigned P_MISO = 6
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] port_q,
  input  logic             pud,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_mosi_out,
  input  logic             spi_miso_out,
  input  logic             cmp_en,
  input  logic             cmp_out,
  input  logic             usart_sync,
  input  logic             usart_clk_out,
  output logic [WIDTH-1:0] oe_d,
  output logic [WIDTH-1:0] out_d,
  output logic [WIDTH-1:0] pue_d
);
  logic spi_slv, spi_mst;
  assign spi_slv = spi_en & ~spi_master;
  assign spi_mst = spi_en &  spi_master;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic force_in, take_val, alt_val;
    if (i == P_MOSI) begin : g_mosi
      assign force_in = spi_slv;
      assign take_val = spi_mst;
      assign alt_val  = spi_mosi_out;
    end else if (i == P_MISO) begin : g_miso
      assign force_in = spi_mst;
      assign take_val = spi_slv;
      assign alt_val  = spi_miso_out;
    end else if (i == P_SS) begin : g_ss
      assign force_in = spi_slv;
      assign take_val = 1'b0;
      assign alt_val  = 1'b0;
    end else if (i == P_CMP) begin : g_cmp
      assign force_in = 1'b0;
      assign take_val = cmp_en & dir_q[i];
      assign alt_val  = cmp_out;
    end else if (i == P_XCK) begin : g_xck
      assign force_in = 1'b0;
      assign take_val = usart_sync & dir_q[i];
      assign alt_val  = usart_clk_out;
    end else begin : g_plain
      assign force_in = 1'b0;
      assign take_val = 1'b0;
      assign alt_val  = 1'b0;
    end
    assign oe_d[i]  = dir_q[i] & ~force_in;
    assign out_d[i] = take_val ? alt_val : port_q[i];
    assign pue_d[i] = ~oe_d[i] & port_q[i] & ~pud;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned P_XCK       = 0,
  parameter int unsigned P_CMP       = 3,
  parameter int unsigned P_SS        = 4,
  parameter int unsigned P_MOSI      = 5,
  parameter int unsigned P_MISO      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              pud,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              spi_mosi_out,
  input  logic              spi_miso_out,
  output logic              spi_sdi,
  output logic              spi_ss_active,
  input  logic              cmp_en,
  input  logic              cmp_out,
  input  logic              usart_sync,
  input  logic              usart_clk_out,
  output logic              usart_clk_in,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pue
);
  logic [WIDTH-1:0] dir_q, port_q, pin_sync;
  logic [WIDTH-1:0] oe_d, out_d, pue_d;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .dir_q(dir_q),
    .port_q(port_q), .bus_rdata(bus_rdata)
  );

  gpio_override #(
    .WIDTH(WIDTH), .P_XCK(P_XCK), .P_CMP(P_CMP), .P_SS(P_SS),
    .P_MOSI(P_MOSI), .P_MISO(P_MISO)
  ) u_ovr (
    .dir_q(dir_q), .port_q(port_q), .pud(pud), .spi_en(spi_en),
    .spi_master(spi_master), .spi_mosi_out(spi_mosi_out),
    .spi_miso_out(spi_miso_out), .cmp_en(cmp_en), .cmp_out(cmp_out),
    .usart_sync(usart_sync), .usart_clk_out(usart_clk_out),
    .oe_d(oe_d), .out_d(out_d), .pue_d(pue_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
      pin_pue <= '0;
    end else begin
      pin_oe  <= oe_d;
      pin_out <= out_d;
      pin_pue <= pue_d;
    end
  end

  assign spi_sdi       = spi_en & (spi_master ? pin_sync[P_MISO] : pin_sync[P_MOSI]);
  assign spi_ss_active = spi_en & ~spi_master & ~pin_sync[P_SS];
  assign usart_clk_in  = usart_sync & ~dir_q[P_XCK] & pin_sync[P_XCK];
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned P_CMP  = 3,
  parameter int unsigned P_SS   = 4,
  parameter int unsigned P_MOSI = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             pud,
  input logic             spi_en,
  input logic             spi_master,
  input logic             cmp_en,
  input logic             spi_ss_active,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_pue
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (pin_oe == '0 && pin_pue == '0 && dir_q == '0)); // R1
  AST_PUE_ONLY_INPUT: assert property (@(posedge clk) disable iff (rst) (pin_pue & pin_oe) == '0); // R4
  AST_SLAVE_FORCE_IN: assert property (@(posedge clk) disable iff (rst) (spi_en && !spi_master) |=> (!pin_oe[P_MOSI] && !pin_oe[P_SS])); // R6
  AST_MASTER_MOSI_DIR: assert property (@(posedge clk) disable iff (rst) (spi_en && spi_master) |=> (pin_oe[P_MOSI] == $past(dir_q[P_MOSI]))); // R7
  AST_SS_ONLY_SLAVE: assert property (@(posedge clk) disable iff (rst) spi_ss_active |-> (spi_en && !spi_master)); // R8
  AST_CMP_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst) (!dir_q[P_CMP]) |=> !pin_oe[P_CMP]); // R10
  AST_PUD_BLOCKS: assert property (@(posedge clk) disable iff (rst) pud |=> (pin_pue == '0)); // R12
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .WIDTH(WIDTH), .P_CMP(P_CMP), .P_SS(P_SS), .P_MOSI(P_MOSI)
) u_chk (
  .clk(clk), .rst(rst), .pud(pud), .spi_en(spi_en), .spi_master(spi_master),
  .cmp_en(cmp_en), .spi_ss_active(spi_ss_active), .dir_q(dir_q),
  .pin_oe(pin_oe), .pin_pue(pin_pue)
);

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic pud = 0, spi_en = 0, spi_master = 0, spi_mosi_out = 0, spi_miso_out = 0;
  logic cmp_en = 0, cmp_out = 0, usart_sync = 0, usart_clk_out = 0;
  logic spi_sdi, spi_ss_active, usart_clk_in;
  logic [7:0] pin_in = '0, pin_out, pin_oe, pin_pue;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pud(pud), .spi_en(spi_en),
    .spi_master(spi_master), .spi_mosi_out(spi_mosi_out),
    .spi_miso_out(spi_miso_out), .spi_sdi(spi_sdi), .spi_ss_active(spi_ss_active),
    .cmp_en(cmp_en), .cmp_out(cmp_out), .usart_sync(usart_sync),
    .usart_clk_out(usart_clk_out), .usart_clk_in(usart_clk_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pue(pin_pue)
  );

  // ctl: [8]pud [7]spi_en [6]spi_master [5]mosi_out [4]miso_out [3]cmp_en [2]cmp_out [1]usart_sync [0]usart_clk_out
  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] port;
    logic [8:0] ctl;
    logic [7:0] e_oe;
    logic [7:0] e_out;
    logic [7:0] e_pue;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'hF0, 8'h3C, 9'h000, 8'hF0, 8'h3C, 8'h0C},
    '{8'hFF, 8'hFF, 9'h100, 8'hFF, 8'hFF, 8'h00},
    '{8'hFF, 8'h30, 9'h090, 8'hCF, 8'h70, 8'h30},
    '{8'h30, 8'hC0, 9'h0E0, 8'h30, 8'hE0, 8'hC0},
    '{8'h40, 8'h40, 9'h0C0, 8'h00, 8'h40, 8'h40},
    '{8'h08, 8'h00, 9'h00C, 8'h08, 8'h08, 8'h00},
    '{8'h00, 8'h08, 9'h008, 8'h00, 8'h08, 8'h08},
    '{8'h01, 8'h00, 9'h003, 8'h01, 8'h01, 8'h00},
    '{8'h00, 8'h01, 9'h003, 8'h00, 8'h01, 8'h01},
    '{8'h01, 8'h00, 9'h001, 8'h01, 8'h00, 8'h00}
  };
  localparam string VTAG [NV] = '{"R3", "R12", "R6", "R7", "R7", "R10", "R10", "R11", "R11", "R11"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_ctl(input logic [8:0] c);
    {pud, spi_en, spi_master, spi_mosi_out, spi_miso_out,
     cmp_en, cmp_out, usart_sync, usart_clk_out} = c;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 pue", pin_pue, 8'h00);
    rst = 1'b0;
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 port", v, 8'h00);

    // vector table
    for (int k = 0; k < NV; k++) begin
      set_ctl(9'h000);
      wr(2'd1, VECS[k].dir);
      wr(2'd2, VECS[k].port);
      set_ctl(VECS[k].ctl);
      @(negedge clk); @(negedge clk);
      chk({VTAG[k], " oe"}, pin_oe, VECS[k].e_oe);
      chk({VTAG[k], " out"}, pin_out, VECS[k].e_out);
      chk({VTAG[k], " pue"}, pin_pue, VECS[k].e_pue);
    end
    set_ctl(9'h000);

    // R2 readback and ignored writes
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
    pin_in = 8'h3C;
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd1, v); chk("R2 dir", v, 8'hA5);
    rd(2'd2, v); chk("R2 port", v, 8'h5A);
    rd(2'd3, v); chk("R2 addr3", v, 8'h00);
    rd(2'd0, v); chk("R2 pin read", v, 8'h3C);
    @(negedge clk);
    chk("R3 oe", pin_oe, 8'hA5);
    chk("R3 out", pin_out, 8'h5A);

    // R5 synchronizer latency, address 0 held
    bus_addr = 2'd0;
    @(negedge clk);
    pin_in = 8'hC3;
    @(negedge clk); @(negedge clk);
    chk("R5 two edges", bus_rdata, 8'h3C);
    @(negedge clk);
    chk("R5 three edges", bus_rdata, 8'hC3);

    // R8 slave select and R9 serial input
    spi_en = 1; spi_master = 0;
    pin_in = 8'h20;           // SS low, MOSI high, MISO low
    repeat (3) @(negedge clk);
    chk("R8 ss active", {7'd0, spi_ss_active}, 8'h01);
    chk("R9 slave sdi", {7'd0, spi_sdi}, 8'h01);
    pin_in = 8'h10;           // SS high
    repeat (3) @(negedge clk);
    chk("R8 ss high", {7'd0, spi_ss_active}, 8'h00);
    spi_master = 1; pin_in = 8'h40;  // SS low, MISO high
    repeat (3) @(negedge clk);
    chk("R8 master", {7'd0, spi_ss_active}, 8'h00);
    chk("R9 master sdi", {7'd0, spi_sdi}, 8'h01);
    spi_en = 0;
    @(negedge clk);
    chk("R9 disabled", {7'd0, spi_sdi}, 8'h00);

    // R11 USART clock input
    wr(2'd1, 8'h00);
    pin_in = 8'h01;
    usart_sync = 1;
    repeat (3) @(negedge clk);
    chk("R11 clk in", {7'd0, usart_clk_in}, 8'h01);
    usart_sync = 0;
    @(negedge clk);
    chk("R11 async", {7'd0, usart_clk_in}, 8'h00);

    // R1 reset again mid-run
    wr(2'd1, 8'hFF);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 re-reset oe", pin_oe, 8'h00);
    rst = 1'b0;
    rd(2'd1, v); chk("R1 re-reset dir", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule